// File: doc/BRIEF.md
# DRAM Bank Page-Policy Controller

This block stands between a memory controller's request path and a single DRAM bank. It takes one read request at a time, each naming a row and a column. It issues the PRECHARGE, ACTIVATE and column READ commands that the bank needs on a two-bit command output. The block keeps track of whether the bank's row buffer is empty or holds a row, and which row that is. Each request is sorted into one of three classes. A hit targets the row that is already open. A miss reaches a bank whose buffer is empty. A conflict finds a different row in the buffer.

A static policy input selects what happens after each access. In open-page operation the row stays in the buffer, which bets on locality. In close-page operation the block precharges the bank right after every access, so every later request begins from an empty buffer. Cycle counts for precharge, activate-to-read and read latency are parameters. A one-cycle completion pulse carries the access class, and three saturating counters, cleared synchronously, tally the classes.

Top module: `dram_bank_ctrl`

## Requirements
- R1: After reset the bank is empty (no open row), `req_ready` is 1, `cmd_op` is 0 (no command), `done` is 0 and all three counters read 0.
- R2: A hit issues only a READ (`cmd_op`=3), in the first cycle after the request is accepted. `done` follows T_CAS cycles after the READ.
- R3: A miss issues ACTIVATE (`cmd_op`=1) in the first cycle after acceptance and READ T_RCD cycles later. `done` comes T_CAS cycles after the READ, so the latency is T_RCD+T_CAS.
- R4: A conflict issues PRECHARGE (`cmd_op`=2) first, ACTIVATE T_RP cycles later and READ T_RCD cycles after that. `done` comes T_CAS cycles after the READ, so the latency is T_RP+T_RCD+T_CAS.
- R5: With `close_page`=0 the row stays open after an access. A following request to the same row is a hit, and no PRECHARGE is issued between the two requests.
- R6: With `close_page`=1 the block issues PRECHARGE in the cycle after `done`. `req_ready` returns T_RP cycles after that PRECHARGE, and every following request is a miss.
- R7: `req_ready` is high only while the block is idle. Outside idle, `req_valid` is ignored: it produces no command, no completion and no change to the open row.
- R8: `done` is a single-cycle pulse, and `done_kind` carries the class during that pulse: 0 for a hit, 1 for a miss, 2 for a conflict.
- R9: Each counter adds 1 on every `done` of its class and holds at 2^CNT_W-1 instead of wrapping.
- R10: When `cnt_clear` is high at a clock edge, all counters are 0 after that edge, even if a completion arrives at the same edge.
- R11: A sequential stream over all 2^COL_W columns of one row gives 2^COL_W-1 hits. With the defaults that is 127 of 128.
- R12: `cmd_row` carries the request row during ACTIVATE and READ. During READ, `cmd_col` carries the request column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_page | input | 1 | Static policy select: 1 = close-page, 0 = open-page |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted at this edge if valid |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cmd_op | output | 2 | Command: 0 none, 1 ACTIVATE, 2 PRECHARGE, 3 READ |
| cmd_row | output | ROW_W | Row address for the command |
| cmd_col | output | COL_W | Column address for the command |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | Class of the completed request |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| hit_count | output | CNT_W | Saturating hit tally |
| miss_count | output | CNT_W | Saturating miss tally |
| conflict_count | output | CNT_W | Saturating conflict tally |

## Verification
The bench builds the block with T_RP=2, T_RCD=3 and T_CAS=4. Because the three values differ, each class has its own latency, and a command that moves one cycle early or late shows up at a distinct offset. CNT_W=3 makes the counters saturate at 7 within a few requests. COL_W=7 gives a full 128-column row, so a whole sequential stream that ends in a conflict on the next row fits in a short run.

// File: rtl/bank_pkg.sv
package bank_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_PRE = 2'd2,
    OP_RD  = 2'd3
  } bank_op_e;

  typedef enum logic [1:0] {
    K_HIT      = 2'd0,
    K_MISS     = 2'd1,
    K_CONFLICT = 2'd2
  } access_kind_e;

  // Class of a request given the buffer state and a row comparison.
  function automatic access_kind_e classify(input logic is_open, input logic same_row);
    if (!is_open)      return K_MISS;
    else if (same_row) return K_HIT;
    else               return K_CONFLICT;
  endfunction

  // Saturating increment against an all-ones ceiling.
  function automatic logic [31:0] sat_step(input logic [31:0] cur, input logic [31:0] top);
    return (cur >= top) ? top : cur + 32'd1;
  endfunction

endpackage

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import bank_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bank_op_e         op,
  input  logic [ROW_W-1:0] op_row,
  input  logic [ROW_W-1:0] req_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output access_kind_e     kind
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else begin
      case (op)
        OP_PRE: is_open <= 1'b0;
        OP_ACT: begin
          is_open  <= 1'b1;
          open_row <= op_row;
        end
        default: ;
      endcase
    end
  end

  assign kind = classify(is_open, open_row == req_row);

  // A READ may only target the row held in an active bank.
  assert_rd_on_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD) |-> (is_open && open_row == op_row));

  // An ACTIVATE may only be issued to an empty bank.
  assert_act_on_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACT) |-> !is_open);

endmodule

// File: rtl/bank_sequencer.sv
module bank_sequencer
  import bank_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RCD = 4,
  parameter int T_CAS = 5,
  parameter int ROW_W = 6,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_page,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  access_kind_e     kind_in,
  output logic             req_ready,
  output bank_op_e         op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             done,
  output access_kind_e     done_kind
);

  localparam int TMAX = (T_RP > T_RCD) ? ((T_RP > T_CAS) ? T_RP : T_CAS)
                                       : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
  localparam int TW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACT, S_RD, S_DONE, S_APRE
  } seq_state_e;

  seq_state_e       state;
  logic [TW-1:0]    cnt;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  access_kind_e     lat_kind;
  logic             accept;
  logic             phase_end;

  function automatic logic [TW-1:0] phase_len(input seq_state_e s);
    case (s)
      S_PRE, S_APRE: return TW'(T_RP);
      S_ACT:         return TW'(T_RCD);
      S_RD:          return TW'(T_CAS);
      default:       return TW'(1);
    endcase
  endfunction

  function automatic seq_state_e phase_next(input seq_state_e s);
    case (s)
      S_PRE:   return S_ACT;
      S_ACT:   return S_RD;
      S_RD:    return S_DONE;
      default: return S_IDLE;
    endcase
  endfunction

  function automatic seq_state_e entry_state(input access_kind_e k);
    case (k)
      K_HIT:   return S_RD;
      K_MISS:  return S_ACT;
      default: return S_PRE;
    endcase
  endfunction

  assign accept    = req_valid && req_ready;
  assign phase_end = (cnt == phase_len(state) - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
      lat_kind <= K_MISS;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state    <= entry_state(kind_in);
          cnt      <= '0;
          lat_row  <= req_row;
          lat_col  <= req_col;
          lat_kind <= kind_in;
        end
        S_DONE: begin
          state <= close_page ? S_APRE : S_IDLE;
          cnt   <= '0;
        end
        default: begin
          if (phase_end) begin
            state <= phase_next(state);
            cnt   <= '0;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    op = OP_NOP;
    if (cnt == '0) begin
      case (state)
        S_PRE, S_APRE: op = OP_PRE;
        S_ACT:         op = OP_ACT;
        S_RD:          op = OP_RD;
        default:       op = OP_NOP;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign done_kind = lat_kind;
  assign cmd_row   = lat_row;
  assign cmd_col   = lat_col;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_close_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && close_page) |=> (op == OP_PRE));

  assert_hit_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_in == K_HIT) |=> (op == OP_RD));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> $stable(lat_row));

endmodule

// File: rtl/kind_counters.sv
module kind_counters
  import bank_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  done,
  input  access_kind_e          kind,
  output logic [2:0][CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (clear)
        cnt[g] <= '0;
      else if (done && kind == access_kind_e'(g))
        cnt[g] <= CNT_W'(sat_step(32'(cnt[g]), 32'(CMAX)));
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && cnt[g] == CMAX) |=> (cnt[g] == CMAX));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt[g] == '0));
  end

endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import bank_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 7,
  parameter int T_RP  = 3,
  parameter int T_RCD = 4,
  parameter int T_CAS = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_page,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic [1:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             done,
  output logic [1:0]       done_kind,
  input  logic             cnt_clear,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count,
  output logic [CNT_W-1:0] conflict_count
);

  bank_op_e              op;
  access_kind_e          kind;
  access_kind_e          dkind;
  logic                  is_open;
  logic [ROW_W-1:0]      open_row;
  logic [2:0][CNT_W-1:0] counts;

  bank_row_tracker #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .op(op), .op_row(cmd_row), .req_row(req_row),
    .is_open(is_open), .open_row(open_row), .kind(kind)
  );

  bank_sequencer #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
                   .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .close_page(close_page), .req_valid(req_valid),
    .req_row(req_row), .req_col(req_col), .kind_in(kind), .req_ready(req_ready),
    .op(op), .cmd_row(cmd_row), .cmd_col(cmd_col), .done(done), .done_kind(dkind)
  );

  kind_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .done(done), .kind(dkind),
    .cnt(counts)
  );

  assign cmd_op         = op;
  assign done_kind      = dkind;
  assign hit_count      = counts[0];
  assign miss_count     = counts[1];
  assign conflict_count = counts[2];

  // Close-page operation never leaves a row open once the bank is idle again.
  assert_close_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && close_page && $past(close_page) && $past(op) == OP_PRE) |-> !is_open);

endmodule

// File: tb/sim_dram_bank_ctrl.sv
module sim_dram_bank_ctrl;

  localparam int CLK   = 10;
  localparam int ROW_W = 6;
  localparam int COL_W = 7;
  localparam int T_RP  = 2;
  localparam int T_RCD = 3;
  localparam int T_CAS = 4;
  localparam int CNT_W = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             close_page = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [1:0]       cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             done;
  logic [1:0]       done_kind;
  logic             cnt_clear = 1'b0;
  logic [CNT_W-1:0] hit_count, miss_count, conflict_count;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  m_open = 0;
  int  m_row = 0;
  int  m_cnt [3] = '{0, 0, 0};
  int  last_kind = -1;
  bit  finished = 0;

  always #(CLK/2) clk = ~clk;

  dram_bank_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD),
                   .T_CAS(T_CAS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .close_page(close_page), .req_valid(req_valid),
    .req_ready(req_ready), .req_row(req_row), .req_col(req_col), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .done(done), .done_kind(done_kind),
    .cnt_clear(cnt_clear), .hit_count(hit_count), .miss_count(miss_count),
    .conflict_count(conflict_count)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_counts(input string tag);
    chk(hit_count == m_cnt[0], tag, "hit_count", hit_count, m_cnt[0]);
    chk(miss_count == m_cnt[1], tag, "miss_count", miss_count, m_cnt[1]);
    chk(conflict_count == m_cnt[2], tag, "conflict_count", conflict_count, m_cnt[2]);
  endtask

  // One request, checked at every cycle offset from acceptance to idle.
  task automatic run_req(input int row, input int col, input bit poke, input bit clr);
    int k, st_rd, d, idle, eop;
    string ktag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    k = !m_open ? 1 : ((m_row == row) ? 0 : 2);
    ktag = (k == 0) ? "R2" : ((k == 1) ? "R3" : "R4");
    st_rd = (k == 0) ? 0 : ((k == 1) ? T_RCD : T_RP + T_RCD);
    d = st_rd + T_CAS;
    idle = close_page ? d + 1 + T_RP : d + 1;
    req_valid = 1'b1;
    req_row = ROW_W'(row);
    req_col = COL_W'(col);
    if (clr) cnt_clear = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int off = 0; off <= idle; off++) begin
      @(negedge clk);
      if (poke && off == 1) begin
        req_valid = 1'b1;
        req_row = ROW_W'(row ^ 20);
      end
      if (poke && off == 2) req_valid = 1'b0;
      eop = 0;
      if (k == 2 && off == 0) eop = 2;
      if (k == 2 && off == T_RP) eop = 1;
      if (k == 1 && off == 0) eop = 1;
      if (off == st_rd) eop = 3;
      if (close_page && off == d + 1) eop = 2;
      chk(cmd_op == 2'(eop), (off > d) ? "R6" : ktag, "cmd_op", cmd_op, eop);
      if (eop == 1 || eop == 3)
        chk(cmd_row == ROW_W'(row), "R12", "cmd_row", cmd_row, row);
      if (eop == 3)
        chk(cmd_col == COL_W'(col), "R12", "cmd_col", cmd_col, col);
      chk(done == (off == d), "R8", "done", done, (off == d));
      if (off == d) begin
        chk(done_kind == 2'(k), "R8", "done_kind", done_kind, k);
        last_kind = done_kind;
      end
      chk(req_ready == (off == idle), close_page ? "R6" : "R7", "req_ready",
          req_ready, (off == idle));
    end
    cnt_clear = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (clr) m_cnt[i] = 0;
      else if (i == k && m_cnt[i] < CMAX) m_cnt[i]++;
    end
    m_open = !close_page;
    m_row = row;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(cmd_op == 2'd0, "R1", "cmd_op", cmd_op, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    check_counts("R1");
  endtask

  task automatic t_open_page();
    close_page = 1'b0;
    run_req(3, 1, 0, 0);   // miss from empty bank (R3)
    run_req(3, 2, 0, 0);   // same row stays open: hit (R5)
    run_req(9, 0, 0, 0);   // other row: conflict (R4)
    run_req(9, 5, 0, 0);   // hit again (R2)
    chk(last_kind == 0, "R5", "kind after reopen", last_kind, 0);
    check_counts("R9");
  endtask

  task automatic t_ignore_busy();
    run_req(9, 6, 1, 0);   // hit with a stray valid pulse while busy
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_op == 2'd0, "R7", "idle cmd_op", cmd_op, 0);
      chk(done == 1'b0, "R7", "idle done", done, 0);
    end
    run_req(9, 7, 0, 0);   // open row unchanged by the stray pulse: hit
    chk(last_kind == 0, "R7", "kind after stray", last_kind, 0);
  endtask

  task automatic t_close_page();
    @(negedge clk);
    close_page = 1'b1;
    run_req(9, 8, 0, 0);   // row 9 still open: conflict, then auto precharge
    run_req(9, 9, 0, 0);   // miss
    chk(last_kind == 1, "R6", "kind in close mode", last_kind, 1);
    run_req(12, 0, 0, 0);  // miss
    chk(last_kind == 1, "R6", "kind in close mode", last_kind, 1);
    check_counts("R6");
    @(negedge clk);
    close_page = 1'b0;
  endtask

  task automatic t_counters();
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    check_counts("R10");
    run_req(4, 0, 0, 0);
    for (int c = 1; c <= 9; c++) run_req(4, c, 0, 0);
    chk(hit_count == CNT_W'(CMAX), "R9", "saturated hits", hit_count, CMAX);
    check_counts("R9");
    run_req(4, 10, 0, 1);  // clear held across a completion edge
    check_counts("R10");
  endtask

  task automatic t_stream();
    int hits = 0;
    for (int c = 0; c < (1 << COL_W); c++) begin
      run_req(40, c, 0, 0);
      if (last_kind == 0) hits++;
    end
    chk(hits == (1 << COL_W) - 1, "R11", "stream hits", hits, (1 << COL_W) - 1);
    run_req(41, 0, 0, 0);
    chk(last_kind == 2, "R11", "next row kind", last_kind, 2);
    check_counts("R9");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_open_page();
    t_ignore_busy();
    t_close_page();
    t_counters();
    t_stream();
    finish_run();
  end

  initial begin
    #(CLK * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule